// File: doc/BRIEF.md
# Double-Buffered Byte-Loaded DAC Code Latch

This block holds the 12-bit code that drives a digital-to-analog converter, loaded from an 8-bit host write port. A write to the low offset places eight bits in a staging register and leaves the converter code alone. A write to the high offset moves the new upper four bits and the staged lower eight bits into the output register together. Because both parts change in the same cycle, the converter never sees a half-updated code.

Software writes the low byte first and the high byte second. Every commit raises a one-cycle update pulse. A converter model samples the new code on that pulse. Read traffic on the same offsets has no path into this block, because it decodes only qualified write strobes.

Top module: `dac_dbl_latch`

## Requirements
- R1: While rst_ni is low, dac_code_o is 0 and dac_upd_o is 0. The staging register is also cleared, so a high-offset write made just after reset with nibble N produces the code {N, 8'h00}.
- R2: A write to offset 4 (wr_en_i=1, addr_i=4) stores wdata_i[7:0] in the staging register. It leaves dac_code_o unchanged and raises no update pulse.
- R3: A write to offset 5 (wr_en_i=1, addr_i=5) sets dac_code_o to {wdata_i[3:0], staged byte} one clock after the write is sampled. Bits [11:8] come from the nibble and bits [7:0] come from the staging register.
- R4: On an offset-5 write, wdata_i[7:4] has no effect on dac_code_o.
- R5: An offset-5 write with no new low byte before it uses whatever byte was staged last.
- R6: A low byte written after a high byte stays staged. dac_code_o keeps the older low byte until the next offset-5 write.
- R7: dac_upd_o is high for exactly the one cycle in which the new code from an offset-5 write first appears. Offset-5 writes on consecutive cycles give a pulse on each of those cycles.
- R8: A cycle with wr_en_i low, at any offset, changes neither the staging register nor dac_code_o. A write to any offset other than 4 or 5 also changes neither.
- R9: Writes on consecutive clock cycles all take effect in order. A low write followed on the very next cycle by a high write commits the byte that has just been staged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| addr_i | input | 4 | Byte offset of the write |
| wdata_i | input | 8 | Write data |
| dac_code_o | output | 12 | Code presented to the converter |
| dac_upd_o | output | 1 | One-cycle pulse on each code commit |

## Verification
The bench goes after four faults:
- **Ordering.** It writes a high byte with no preceding low byte, and writes a low byte after the high byte. A latch that passed the low byte straight through would show a stray code, and one that dropped the staging register would show zero low bits.
- **Consecutive writes.** Low-then-high on adjacent cycles exposes a design that commits the staged value one cycle stale. Adjacent high writes expose a pulse that was stretched or merged.
- **Ignored bits.** Nibble writes with the upper data bits set catch a design that lets those bits reach the code.
- **Gating.** Strobe-low cycles at offsets 4 and 5 catch a design that decodes the offset without the strobe.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;
  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_LO   = 2'd1,
    WR_HI   = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode
  import dac_latch_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LO_OFS = 4,
  parameter int unsigned HI_OFS = 5
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_kind_e          kind_o
);
  localparam logic [ADDR_W-1:0] LoAddr = ADDR_W'(LO_OFS);
  localparam logic [ADDR_W-1:0] HiAddr = ADDR_W'(HI_OFS);

  always_comb begin
    kind_o = WR_NONE;
    if (wr_en_i) begin
      if (addr_i == HiAddr)      kind_o = WR_HI;
      else if (addr_i == LoAddr) kind_o = WR_LO;
    end
  end
endmodule

// File: rtl/dac_stage_reg.sv
module dac_stage_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/dac_out_latch.sv
module dac_out_latch #(
  parameter int unsigned LO_W = 8,
  parameter int unsigned HI_W = 4,
  localparam int unsigned CODE_W = LO_W + HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic [LO_W-1:0]   lo_i,
  output logic [CODE_W-1:0] code_o,
  output logic              upd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= '0;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= commit_i;
      if (commit_i) code_o <= {hi_i, lo_i};
    end
  end
endmodule

// File: rtl/dac_dbl_latch.sv
module dac_dbl_latch
  import dac_latch_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CODE_W = 12,
  parameter int unsigned LO_OFS = 4,
  parameter int unsigned HI_OFS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              dac_upd_o
);
  localparam int unsigned HI_W = CODE_W - DATA_W;

  wr_kind_e          kind;
  logic [DATA_W-1:0] staged;

  dac_wr_decode #(
    .ADDR_W(ADDR_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)
  ) u_dec (
    .wr_en_i(wr_en_i), .addr_i(addr_i), .kind_o(kind)
  );

  dac_stage_reg #(.W(DATA_W)) u_stage (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(kind == WR_LO), .d_i(wdata_i), .q_o(staged)
  );

  // commit uses the staged byte as it stood before this edge
  dac_out_latch #(.LO_W(DATA_W), .HI_W(HI_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .commit_i(kind == WR_HI),
    .hi_i(wdata_i[HI_W-1:0]), .lo_i(staged),
    .code_o(dac_code_o), .upd_o(dac_upd_o)
  );
endmodule

// File: rtl/dac_dbl_latch_chk.sv
module dac_dbl_latch_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CODE_W = 12,
  parameter int unsigned LO_OFS = 4,
  parameter int unsigned HI_OFS = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [CODE_W-1:0] dac_code_o,
  input logic              dac_upd_o
);
  localparam int unsigned HI_W = CODE_W - DATA_W;

  logic [1:0] seen;
  logic       hi_wr, lo_wr;

  assign hi_wr = wr_en_i && (addr_i == ADDR_W'(HI_OFS));
  assign lo_wr = wr_en_i && (addr_i == ADDR_W'(LO_OFS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          seen <= '0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_zero_r1: assert (dac_code_o == '0 && !dac_upd_o);
    end
  end

  p_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen != 2'd0) |-> (dac_upd_o == $past(hi_wr)));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen != 2'd0 && !$past(hi_wr)) |-> $stable(dac_code_o));

  p_nibble_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen != 2'd0 && $past(hi_wr)) |->
      (dac_code_o[CODE_W-1:DATA_W] == $past(wdata_i[HI_W-1:0])));

  p_lo_then_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen == 2'd3 && $past(hi_wr) && $past(lo_wr, 2)) |->
      (dac_code_o[DATA_W-1:0] == $past(wdata_i, 2)));
endmodule

bind dac_dbl_latch dac_dbl_latch_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W),
  .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .dac_code_o(dac_code_o), .dac_upd_o(dac_upd_o)
);

// File: tb/dac_dbl_latch_test.sv
module dac_dbl_latch_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [11:0] code;
  logic        upd;

  int total = 0;
  int bad = 0;
  logic [7:0]  exp_stage = '0;
  logic [11:0] exp_code = '0;
  logic        exp_upd = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_dbl_latch uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .dac_code_o(code), .dac_upd_o(upd)
  );

  function automatic logic [11:0] commit_val(logic [7:0] d, logic [7:0] st);
    return {d[3:0], st};
  endfunction

  task automatic check(string tag);
    total++;
    if (code !== exp_code || upd !== exp_upd) begin
      bad++;
      $display("FAIL %s: code=%h upd=%b expected code=%h upd=%b",
               tag, code, upd, exp_code, exp_upd);
    end
  endtask

  task automatic step(logic we, logic [3:0] a, logic [7:0] d, string tag);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d;
    @(posedge clk);
    exp_upd = 1'b0;
    if (we && a == 4'd5) begin
      exp_code = commit_val(d, exp_stage);
      exp_upd  = 1'b1;
    end else if (we && a == 4'd4) begin
      exp_stage = d;
    end
    #(CLK_PERIOD/4);
    check(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R9: watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1");
    @(negedge clk); rst_n = 1'b1;
    #1; check("R1");

    step(1, 4'd5, 8'h0A, "R1");       // staging cleared: {A,00}
    step(1, 4'd4, 8'h5C, "R2");
    step(0, 4'd0, 8'h00, "R2");
    step(1, 4'd5, 8'hF3, "R4");       // upper bits ignored -> 35C
    step(1, 4'd5, 8'h07, "R5");       // reuses 5C -> 75C
    step(0, 4'd5, 8'h09, "R8");
    step(0, 4'd4, 8'hEE, "R8");
    step(1, 4'd7, 8'h11, "R8");
    step(1, 4'd5, 8'h01, "R8");       // staging still 5C -> 15C
    step(1, 4'd4, 8'hA5, "R6");
    step(0, 4'd0, 8'h00, "R6");
    step(1, 4'd5, 8'h02, "R6");       // -> 2A5
    step(1, 4'd4, 8'h3C, "R9");
    step(1, 4'd5, 8'h0E, "R9");       // adjacent -> E3C
    step(1, 4'd5, 8'h0D, "R7");
    step(1, 4'd5, 8'h0C, "R7");
    step(0, 4'd0, 8'h00, "R7");

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a;
      logic       we;
      string      tg;
      int unsigned r = $urandom % 10;
      a  = (r < 4) ? 4'd4 : (r < 8) ? 4'd5 : 4'($urandom);
      we = ($urandom % 5) != 0;
      tg = (we && a == 4'd5) ? "R3" : (we && a == 4'd4) ? "R2" : "R8";
      step(we, a, 8'($urandom), tg);
    end

    @(negedge clk);
    wr_en = 1'b0; rst_n = 1'b0;
    exp_code = '0; exp_upd = 1'b0; exp_stage = '0;
    #1; check("R1");
    @(negedge clk); rst_n = 1'b1;
    step(1, 4'd5, 8'h06, "R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule